// File: doc/BRIEF.md
# Receive Sampling Phase Window Tuner

This controller chooses the receive sampling phase for a high-speed SD card link. On a start pulse it first checks whether tuning is needed at all. Tuning runs only when the link is in one of the two 200 MHz-class timing modes and the actual card clock is above 50 MHz. Otherwise it reports completion at once and touches nothing.

When tuning is needed, the controller turns on the delay line and waits for it to lock. It then steps a tap-select value from zero up to a given maximum. Each tap value is handed to the delay line through a one-cycle apply strobe and an acknowledge. After each acknowledge, the controller asks an external test agent to run one tuning-block transfer, and the agent answers with a done pulse and a pass bit. The controller tracks the longest run of consecutive passing phases. When the sweep ends, it programs the centre of that run as the final phase.

If no phase passes, or if the lock or an acknowledge does not arrive in time, the controller ends with an error.

Top module: `phase_tuner`

## Requirements
- R1: After reset, done, error, tap_apply, run_test and line_en are low, and chosen_phase is 0.
- R2: Tuning runs only when the mode code is 4 (SDR104-class) or 5 (HS200-class) and clk_fast is high. For any other start, done pulses high, with error low, in the cycle after the clock edge that samples start. No tap is applied and line_en stays low.
- R3: For an eligible start, line_en rises and no tap_apply occurs before line_lock is seen high.
- R4: Phases 0 up to max_phase inclusive are applied in rising order. Each apply is a tap_apply strobe exactly one cycle long, with the value on tap_value.
- R5: run_test rises only in the cycle after tap_ack was high. It then stays high, with tap_value unchanged, until test_done is seen.
- R6: A failing phase resets the current run length to zero, and a passing phase adds one to it. The best run is replaced only when the current run is strictly longer, so the earliest of equal-length runs is kept. The final phase is the last phase of the best run minus half its length, rounded down.
- R7: After the sweep, the final phase is applied with one more strobe and acknowledge. Then done pulses with error low, and chosen_phase holds the final phase.
- R8: If no phase passes, done pulses with error high, and no final apply follows the sweep. Error is never high without done.
- R9: If line_lock, or a tap_ack, does not arrive within TIMEOUT_CYC cycles of waiting, done pulses with error high and the sweep stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a tuning attempt; sampled only when idle |
| max_phase | input | PHASE_W | Highest phase in the sweep, captured at start |
| mode | input | 3 | Link timing-mode code |
| clk_fast | input | 1 | High when the actual card clock is above 50 MHz |
| line_en | output | 1 | Delay line enable, held high during a tuning attempt |
| line_lock | input | 1 | Delay line reports lock |
| tap_value | output | PHASE_W | Tap-select value to program |
| tap_apply | output | 1 | One-cycle strobe to load tap_value |
| tap_ack | input | 1 | Delay line acknowledges the tap load |
| run_test | output | 1 | Request for one tuning-block transfer; held until test_done |
| test_done | input | 1 | Pulse that ends a test transfer |
| test_pass | input | 1 | Result that comes with test_done (1 = pass) |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | High together with done when tuning failed |
| chosen_phase | output | PHASE_W | Last programmed final phase |

## Verification
The assertions check several things on every cycle: each apply strobe is a single cycle long; a test request starts only after an acknowledge and is held with a steady tap value until the test finishes; the apply strobe, the test request and done never coincide; and no tap is applied before the delay line is enabled. Only the bench's scenarios can show the window arithmetic, that is, which phase is picked for a given pass/fail pattern, including ties and runs at the edges of the sweep. The same holds for the skip decision across every mode code and clock flag, and for the two timeout paths. To cover these, the bench sweeps every pass/fail pattern of an eight-phase sweep and compares each result against a value it computes itself.

// File: rtl/tuner_pkg.sv
package tuner_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOCK,
    ST_APPLY,
    ST_ACKW,
    ST_TEST,
    ST_EVAL,
    ST_FIN
  } tuner_state_t;

  localparam logic [2:0] MODE_SDR104 = 3'd4;
  localparam logic [2:0] MODE_HS200  = 3'd5;

  function automatic logic tuning_needed(input logic [2:0] md, input logic fast);
    return fast && (md == MODE_SDR104 || md == MODE_HS200);
  endfunction

endpackage

// File: rtl/tuner_timer.sv
module tuner_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic waiting,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!waiting)   cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = waiting && (cnt_q == LAST);
endmodule

// File: rtl/tuner_window.sv
module tuner_window #(
  parameter int PHASE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               step,
  input  logic               pass,
  input  logic [PHASE_W-1:0] phase,
  output logic               any_pass,
  output logic [PHASE_W-1:0] centre
);
  localparam int LW = PHASE_W + 1;

  logic [LW-1:0]      run_q, best_q;
  logic [PHASE_W-1:0] end_q;
  logic [LW-1:0]      run_nx;
  logic [LW-1:0]      mid_full;

  assign run_nx = run_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      best_q <= '0;
      end_q  <= '0;
    end else if (clear) begin
      run_q  <= '0;
      best_q <= '0;
      end_q  <= '0;
    end else if (step) begin
      if (!pass) begin
        run_q <= '0;
      end else begin
        run_q <= run_nx;
        if (run_nx > best_q) begin
          best_q <= run_nx;
          end_q  <= phase;
        end
      end
    end
  end

  assign any_pass = (best_q != '0);
  assign mid_full = {1'b0, end_q} - (best_q >> 1);
  assign centre   = mid_full[PHASE_W-1:0];
endmodule

// File: rtl/phase_tuner.sv
module phase_tuner
  import tuner_pkg::*;
#(
  parameter int PHASE_W     = 6,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [PHASE_W-1:0] max_phase,
  input  logic [2:0]         mode,
  input  logic               clk_fast,
  output logic               line_en,
  input  logic               line_lock,
  output logic [PHASE_W-1:0] tap_value,
  output logic               tap_apply,
  input  logic               tap_ack,
  output logic               run_test,
  input  logic               test_done,
  input  logic               test_pass,
  output logic               done,
  output logic               error,
  output logic [PHASE_W-1:0] chosen_phase
);
  tuner_state_t       st_q;
  logic [PHASE_W-1:0] max_q, phase_q, chosen_q;
  logic               final_q, err_q, en_q;
  logic               tmo, waiting, win_clear, win_step, any_pass;
  logic [PHASE_W-1:0] centre;

  assign waiting   = (st_q == ST_LOCK && !line_lock) || (st_q == ST_ACKW && !tap_ack);
  assign win_clear = (st_q == ST_IDLE) && start;
  assign win_step  = (st_q == ST_TEST) && test_done;

  tuner_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .waiting(waiting), .expired(tmo)
  );

  tuner_window #(.PHASE_W(PHASE_W)) u_window (
    .clk(clk), .rst_n(rst_n), .clear(win_clear), .step(win_step),
    .pass(test_pass), .phase(phase_q), .any_pass(any_pass), .centre(centre)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      max_q    <= '0;
      phase_q  <= '0;
      chosen_q <= '0;
      final_q  <= 1'b0;
      err_q    <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          max_q <= max_phase;
          err_q <= 1'b0;
          if (tuning_needed(mode, clk_fast)) begin
            en_q <= 1'b1;
            st_q <= ST_LOCK;
          end else begin
            st_q <= ST_FIN;
          end
        end
        ST_LOCK: if (line_lock) begin
          phase_q <= '0;
          final_q <= 1'b0;
          st_q    <= ST_APPLY;
        end else if (tmo) begin
          err_q <= 1'b1;
          st_q  <= ST_FIN;
        end
        ST_APPLY: st_q <= ST_ACKW;
        ST_ACKW: if (tap_ack) begin
          st_q <= final_q ? ST_FIN : ST_TEST;
        end else if (tmo) begin
          err_q <= 1'b1;
          st_q  <= ST_FIN;
        end
        ST_TEST: if (test_done) begin
          if (phase_q == max_q) begin
            st_q <= ST_EVAL;
          end else begin
            phase_q <= phase_q + 1'b1;
            st_q    <= ST_APPLY;
          end
        end
        ST_EVAL: if (!any_pass) begin
          err_q <= 1'b1;
          st_q  <= ST_FIN;
        end else begin
          phase_q  <= centre;
          chosen_q <= centre;
          final_q  <= 1'b1;
          st_q     <= ST_APPLY;
        end
        ST_FIN: begin
          en_q <= 1'b0;
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign line_en      = en_q;
  assign tap_value    = phase_q;
  assign tap_apply    = (st_q == ST_APPLY);
  assign run_test     = (st_q == ST_TEST);
  assign done         = (st_q == ST_FIN);
  assign error        = done && err_q;
  assign chosen_phase = chosen_q;
endmodule

// File: rtl/phase_tuner_chk.sv
module phase_tuner_chk #(
  parameter int PHASE_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               line_en,
  input logic [PHASE_W-1:0] tap_value,
  input logic               tap_apply,
  input logic               tap_ack,
  input logic               run_test,
  input logic               test_done,
  input logic               done,
  input logic               error
);
  assert_apply_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tap_apply |=> !tap_apply);

  assert_test_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_test) |-> $past(tap_ack));

  assert_test_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_test && !test_done) |=> run_test);

  assert_tap_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_test && $past(run_test)) |-> $stable(tap_value));

  assert_error_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);

  assert_apply_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tap_apply |-> line_en);

  assert_outputs_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tap_apply, run_test, done}));
endmodule

bind phase_tuner phase_tuner_chk #(.PHASE_W(PHASE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_en(line_en), .tap_value(tap_value),
  .tap_apply(tap_apply), .tap_ack(tap_ack), .run_test(run_test),
  .test_done(test_done), .done(done), .error(error)
);

// File: tb/phase_tuner_bench.sv
module phase_tuner_bench;
  localparam int PW  = 6;
  localparam int TMO = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [PW-1:0] max_phase = '0;
  logic [2:0] mode = 3'd0;
  logic clk_fast = 1'b0;
  logic line_en, line_lock = 1'b0;
  logic [PW-1:0] tap_value;
  logic tap_apply, tap_ack = 1'b0;
  logic run_test, test_done = 1'b0, test_pass = 1'b0;
  logic done, error;
  logic [PW-1:0] chosen_phase;

  phase_tuner #(.PHASE_W(PW), .TIMEOUT_CYC(TMO)) u_phase_tuner (.*);

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  logic [63:0] mask = '0;
  bit lock_ok = 1, ack_ok = 1;
  int apply_cnt = 0, order_bad = 0, lock_cnt = 0, test_cd = 0, ack_cd = 0;
  bit applied_before_lock = 0, en_seen = 0;
  logic [PW-1:0] last_tap = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Responders: lock, tap acknowledge, test agent (all at falling edges).
  initial begin
    forever begin
      @(negedge clk);
      tap_ack = 1'b0;
      if (line_en) en_seen = 1;
      if (line_en && lock_ok) begin
        lock_cnt++;
        line_lock = (lock_cnt >= 3);
      end else if (!line_en) begin
        lock_cnt = 0;
        line_lock = 1'b0;
      end
      if (ack_cd == 1) begin
        tap_ack = 1'b1;
        ack_cd = 0;
      end
      if (tap_apply) begin
        if (!line_lock) applied_before_lock = 1;
        if (apply_cnt <= int'(max_phase) && tap_value != PW'(apply_cnt)) order_bad++;
        apply_cnt++;
        last_tap = tap_value;
        if (ack_ok) ack_cd = 1;
      end
      if (test_done) begin
        test_done = 1'b0;
      end else if (test_cd == 1) begin
        test_done = 1'b1;
        test_pass = mask[tap_value];
        test_cd = 0;
      end else if (run_test) begin
        test_cd = 1;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Expected window centre, from the R6 rules.
  task automatic expect_window(input logic [63:0] m, input int mx,
                               output bit found, output int ph);
    int cur = 0, best = 0, ende = 0;
    for (int p = 0; p <= mx; p++) begin
      if (m[p]) begin
        cur++;
        if (cur > best) begin best = cur; ende = p; end
      end else cur = 0;
    end
    found = (best > 0);
    ph = ende - best / 2;
  endtask

  task automatic launch(input logic [63:0] m, input int mx, input logic [2:0] md,
                        input bit fast, output int wait_cyc);
    mask = m; max_phase = PW'(mx); mode = md; clk_fast = fast;
    apply_cnt = 0; order_bad = 0; applied_before_lock = 0; en_seen = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_cyc = 1;
    while (!done && wait_cyc < 5000) begin
      @(negedge clk);
      wait_cyc++;
    end
  endtask

  task automatic sweep_case(input logic [63:0] m, input int mx, input logic [2:0] md);
    bit found; int ph, wc;
    expect_window(m, mx, found, ph);
    launch(m, mx, md, 1'b1, wc);
    chk(done === 1'b1, "R7 done", int'(done), 1);
    chk(error === !found, "R8 error flag", int'(error), int'(!found));
    chk(order_bad == 0 && !applied_before_lock && en_seen, "R3/R4 sweep order",
        order_bad, 0);
    chk(apply_cnt == mx + 1 + (found ? 1 : 0), "R4 apply count", apply_cnt,
        mx + 1 + (found ? 1 : 0));
    if (found) begin
      chk(int'(chosen_phase) == ph, "R6 chosen phase", int'(chosen_phase), ph);
      chk(int'(last_tap) == ph, "R7 final tap", int'(last_tap), ph);
    end
  endtask

  initial begin
    int wc;
    repeat (3) @(negedge clk);
    chk(!done && !error && !tap_apply && !run_test && !line_en, "R1 idle outputs",
        int'({done, error, tap_apply, run_test, line_en}), 0);
    chk(chosen_phase == '0, "R1 chosen reset", int'(chosen_phase), 0);
    rst_n = 1'b1;

    // R2: every ineligible mode/clock combination
    for (int md = 0; md < 8; md++) begin
      for (int f = 0; f < 2; f++) begin
        if (!((md == 4 || md == 5) && f == 1)) begin
          launch(64'hFF, 7, 3'(md), f[0], wc);
          chk(wc == 1 && !error, "R2 skip done timing", wc, 1);
          chk(apply_cnt == 0 && !en_seen, "R2 skip no activity", apply_cnt, 0);
        end
      end
    end

    // R6/R7/R8: every pass pattern over eight phases, both eligible modes
    for (int m = 0; m < 256; m++)
      sweep_case(64'(m), 7, (m % 2 == 0) ? 3'd4 : 3'd5);

    // R6: ties keep the earliest run, full 32-tap sweep, edge runs
    sweep_case(64'h0000_0000_F00F_0000, 31, 3'd4);
    sweep_case(64'h0000_0000_FFFF_FFFF, 31, 3'd5);
    sweep_case(64'h0000_0000_8000_0001, 31, 3'd4);
    sweep_case(64'h0000_0000_0000_0001, 0, 3'd5);
    sweep_case(64'hFFFF_FFFF_FFFF_FFFE, 63, 3'd4);

    // R9: lock never arrives
    lock_ok = 0;
    launch(64'hFF, 7, 3'd4, 1'b1, wc);
    chk(done && error, "R9 lock timeout error", int'(error), 1);
    chk(apply_cnt == 0, "R9 no apply without lock", apply_cnt, 0);
    chk(wc >= TMO && wc <= TMO + 4, "R9 lock timeout span", wc, TMO);
    lock_ok = 1;
    repeat (3) @(negedge clk);

    // R9: tap acknowledge never arrives
    ack_ok = 0;
    launch(64'hFF, 7, 3'd5, 1'b1, wc);
    chk(done && error, "R9 ack timeout error", int'(error), 1);
    chk(apply_cnt == 1, "R9 sweep stops", apply_cnt, 1);
    ack_ok = 1;
    repeat (3) @(negedge clk);

    // R7: normal run after an error
    sweep_case(64'h3C, 7, 3'd4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule